// File: doc/BRIEF.md
# I2C Control Register Port with Outbound Mailbox

This block is a two-wire serial slave that lets an external host reach a bank of up to 128 byte-wide control registers. Each transfer names a register through a pointer byte sent right after the slave address. The top bit of that pointer byte selects auto-increment. Writes then flow to the register bank through a single-cycle write strobe. Reads use a repeated START and fetch bytes from the bank, most significant bit first.

One register address is reserved for a one-byte outbound mailbox that an on-chip processor fills through a write strobe. A request output tells the host that a mailbox byte is waiting. While the host reads the mailbox, the request is re-evaluated at the SCL rising edge of bit D1 of the outgoing byte. It stays high if the processor has refilled the mailbox by then. It falls if the mailbox is empty, and it rises again as soon as a later refill lands.

SCL and SDA are sampled by a system clock running at least eight times the SCL rate. SDA is open-drain: the block only drives it low, through `sda_oe`.

Top module: `i2c_mailbox_port`

## Requirements
- R1: A START (SDA falling while SCL high) begins address reception from any state. A STOP (SDA rising while SCL high) returns the port to idle with SDA released. A byte cut short by STOP writes nothing.
- R2: When the upper seven bits of the first byte equal `SLAVE_ADDR`, the port pulls SDA low for the ACK bit. Otherwise it never drives SDA, and it writes nothing until the next START.
- R3: The byte after an address with R/W=0 is the pointer byte. Bit 7 is the auto-increment enable and bits 6:0 are the register address. The port ACKs it.
- R4: With auto-increment on, the data bytes of one write transfer land at consecutive register addresses. Each produces exactly one single-cycle `reg_wr` pulse and is ACKed.
- R5: With auto-increment off, every data byte of one write transfer goes to the same register, so the last byte written is the one that stays.
- R6: After a repeated START with R/W=1, the port returns the register at the pointer, MSB first. It continues while the master ACKs and stops driving after a NACK. With auto-increment on, each byte comes from the next address.
- R7: A processor write fills the mailbox and raises `req` on the next cycle. A read at address `MBOX_ADDR` (default 7'h7F) returns the mailbox byte.
- R8: If no refill has arrived by the SCL rising edge of bit D1 of a mailbox byte being read, `req` falls within a few system cycles and stays low.
- R9: If the processor refills the mailbox before that D1 rising edge, `req` stays high through the whole byte with no gap, and the next byte read returns the new value.
- R10: If the processor refills after that D1 rising edge, `req` falls and then rises again, giving a low pulse. The new byte is kept and can be read in a later transfer.
- R11: The port changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When 1, SDA is pulled low |
| proc_wr | input | 1 | Processor strobe that loads the mailbox |
| proc_data | input | 8 | Mailbox byte from the processor |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_addr | output | 7 | Register address for write, or for read data |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for `reg_addr` (combinational) |
| req | output | 1 | Mailbox byte waiting for the host |

## Verification
The point where the host consumes the mailbox byte (the D1 rising edge) and the processor's refill strobe can land close together. Which of them comes first decides whether `req` holds, falls, or pulses. The bench fires the refill strobe in the low phase just before D1 and in the low phase of D0 after it. A monitor records any low sample of `req` across the byte. It then judges the level left on `req` and the byte returned by the following read against the expected outcome for that ordering.

// File: rtl/i2cmb_pkg.sv
package i2cmb_pkg;

    localparam int REG_AW = 7;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W) + 1;

    typedef enum logic [3:0] {
        PS_IDLE,
        PS_ADDR,
        PS_ADDR_ACK,
        PS_PTR,
        PS_PTR_ACK,
        PS_WDATA,
        PS_WDATA_ACK,
        PS_RDATA,
        PS_RDATA_ACK
    } port_state_e;

    typedef struct packed {
        port_state_e             st;
        logic [CNT_W-1:0]        cnt;
        logic [DATA_W-1:0]       rx;
        logic [DATA_W-1:0]       tx;
        logic [REG_AW-1:0]       ptr;
        logic                    incr;
        logic                    rw;
        logic                    mack;
        logic                    oe;
        logic                    wr;
        logic [REG_AW-1:0]       wr_addr;
        logic [DATA_W-1:0]       wr_data;
        logic                    take;
        logic                    d1;
        logic                    bend;
    } port_regs_t;

endpackage

// File: rtl/i2cmb_sync.sv
module i2cmb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic cond_start,
    output logic cond_stop
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sr;
        logic [STAGES-1:0] sda_sr;
        logic              scl_p;
        logic              sda_p;
    } sync_regs_t;

    sync_regs_t sy_q, sy_d;

    always_comb begin
        sy_d        = sy_q;
        sy_d.scl_sr = {sy_q.scl_sr[STAGES-2:0], scl_i};
        sy_d.sda_sr = {sy_q.sda_sr[STAGES-2:0], sda_i};
        sy_d.scl_p  = sy_q.scl_sr[STAGES-1];
        sy_d.sda_p  = sy_q.sda_sr[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '1;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign scl_s      = sy_q.scl_sr[STAGES-1];
    assign sda_s      = sy_q.sda_sr[STAGES-1];
    assign scl_rise   = scl_s && !sy_q.scl_p;
    assign scl_fall   = !scl_s && sy_q.scl_p;
    assign cond_start = scl_s && sy_q.scl_p && !sda_s && sy_q.sda_p;
    assign cond_stop  = scl_s && sy_q.scl_p && sda_s && !sy_q.sda_p;

endmodule

// File: rtl/i2cmb_mailbox.sv
module i2cmb_mailbox
    import i2cmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_wr,
    input  logic [DATA_W-1:0] proc_data,
    input  logic              take_i,
    input  logic              d1_i,
    input  logic              bend_i,
    input  logic              abort_i,
    output logic [DATA_W-1:0] mb_data,
    output logic              req
);

    typedef struct packed {
        logic              full;
        logic              busy;
        logic              d1;
        logic [DATA_W-1:0] data;
        logic              req;
    } mb_regs_t;

    mb_regs_t mb_q, mb_d;

    always_comb begin
        mb_d = mb_q;
        if (take_i) begin
            mb_d.full = 1'b0;
            mb_d.busy = 1'b1;
            mb_d.d1   = 1'b0;
        end
        if (d1_i && mb_q.busy) begin
            mb_d.d1 = 1'b1;
        end
        if (bend_i || abort_i) begin
            mb_d.busy = 1'b0;
            mb_d.d1   = 1'b0;
        end
        if (proc_wr) begin
            mb_d.full = 1'b1;
            mb_d.data = proc_data;
        end
        mb_d.req = mb_d.full || (mb_d.busy && !mb_d.d1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mb_q <= '0;
        end else begin
            mb_q <= mb_d;
        end
    end

    assign mb_data = mb_q.data;
    assign req     = mb_q.req;

    AST_FILL_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        proc_wr |=> req); // R7

    AST_EMPTY_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (d1_i && mb_q.busy && !mb_q.full && !proc_wr && !take_i) |=> !req); // R8

    AST_REFILL_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mb_q.full |=> req); // R9

endmodule

// File: rtl/i2c_mailbox_port.sv
module i2c_mailbox_port
    import i2cmb_pkg::*;
#(
    parameter logic [REG_AW-1:0] SLAVE_ADDR  = 7'h2A,
    parameter logic [REG_AW-1:0] MBOX_ADDR   = 7'h7F,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              proc_wr,
    input  logic [DATA_W-1:0] proc_data,
    output logic              reg_wr,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              req
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] D1_CNT   = CNT_W'(DATA_W - 2);

    logic              scl_s, sda_s;
    logic              ev_rise, ev_fall, ev_start, ev_stop;
    logic [DATA_W-1:0] mb_data;
    logic [DATA_W-1:0] load_byte;
    logic              load_mbox;

    port_regs_t q, n;

    i2cmb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (ev_rise),
        .scl_fall   (ev_fall),
        .cond_start (ev_start),
        .cond_stop  (ev_stop)
    );

    i2cmb_mailbox u_mbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .proc_wr   (proc_wr),
        .proc_data (proc_data),
        .take_i    (q.take),
        .d1_i      (q.d1),
        .bend_i    (q.bend),
        .abort_i   (ev_start || ev_stop),
        .mb_data   (mb_data),
        .req       (req)
    );

    assign load_mbox = (q.ptr == MBOX_ADDR);
    assign load_byte = load_mbox ? mb_data : reg_rdata;

    always_comb begin
        n      = q;
        n.wr   = 1'b0;
        n.take = 1'b0;
        n.d1   = 1'b0;
        n.bend = 1'b0;
        if (ev_start) begin
            n.st  = PS_ADDR;
            n.cnt = '0;
            n.oe  = 1'b0;
        end else if (ev_stop) begin
            n.st  = PS_IDLE;
            n.cnt = '0;
            n.oe  = 1'b0;
        end else begin
            if (ev_rise) begin
                if (q.st inside {PS_ADDR, PS_PTR, PS_WDATA, PS_RDATA}) begin
                    n.rx  = {q.rx[DATA_W-2:0], sda_s};
                    n.cnt = q.cnt + 1'b1;
                    if (q.st == PS_RDATA && q.cnt == D1_CNT) begin
                        n.d1 = 1'b1;
                    end
                end
                if (q.st == PS_RDATA_ACK) begin
                    n.mack = !sda_s;
                end
            end
            if (ev_fall) begin
                unique case (q.st)
                    PS_ADDR: begin
                        if (q.cnt == FULL_CNT) begin
                            if (q.rx[DATA_W-1:1] == SLAVE_ADDR) begin
                                n.st = PS_ADDR_ACK;
                                n.rw = q.rx[0];
                                n.oe = 1'b1;
                            end else begin
                                n.st = PS_IDLE;
                            end
                        end
                    end
                    PS_ADDR_ACK, PS_RDATA_ACK: begin
                        if ((q.st == PS_ADDR_ACK && q.rw) ||
                            (q.st == PS_RDATA_ACK && q.mack)) begin
                            n.st   = PS_RDATA;
                            n.tx   = load_byte;
                            n.oe   = !load_byte[DATA_W-1];
                            n.cnt  = '0;
                            n.mack = 1'b0;
                            n.take = load_mbox;
                        end else if (q.st == PS_ADDR_ACK) begin
                            n.st  = PS_PTR;
                            n.oe  = 1'b0;
                            n.cnt = '0;
                        end else begin
                            n.st = PS_IDLE;
                        end
                    end
                    PS_PTR: begin
                        if (q.cnt == FULL_CNT) begin
                            n.ptr  = q.rx[REG_AW-1:0];
                            n.incr = q.rx[DATA_W-1];
                            n.oe   = 1'b1;
                            n.st   = PS_PTR_ACK;
                        end
                    end
                    PS_PTR_ACK, PS_WDATA_ACK: begin
                        n.oe  = 1'b0;
                        n.cnt = '0;
                        n.st  = PS_WDATA;
                    end
                    PS_WDATA: begin
                        if (q.cnt == FULL_CNT) begin
                            n.wr      = 1'b1;
                            n.wr_addr = q.ptr;
                            n.wr_data = q.rx;
                            if (q.incr) begin
                                n.ptr = q.ptr + 1'b1;
                            end
                            n.oe = 1'b1;
                            n.st = PS_WDATA_ACK;
                        end
                    end
                    PS_RDATA: begin
                        if (q.cnt == FULL_CNT) begin
                            n.oe   = 1'b0;
                            n.st   = PS_RDATA_ACK;
                            n.bend = 1'b1;
                            if (q.incr) begin
                                n.ptr = q.ptr + 1'b1;
                            end
                        end else if (q.cnt != '0) begin
                            n.tx = {q.tx[DATA_W-2:0], 1'b0};
                            n.oe = !q.tx[DATA_W-2];
                        end
                    end
                    default: begin
                        n.oe = 1'b0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= PS_IDLE;
        end else begin
            q <= n;
        end
    end

    assign sda_oe    = q.oe;
    assign reg_wr    = q.wr;
    assign reg_addr  = q.wr ? q.wr_addr : q.ptr;
    assign reg_wdata = q.wr_data;

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PS_IDLE) |-> !sda_oe); // R1

    AST_MISMATCH_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fall && q.st == PS_ADDR && q.cnt == FULL_CNT &&
         q.rx[DATA_W-1:1] != SLAVE_ADDR) |=> !sda_oe); // R2

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr); // R4

    AST_OE_MOVES_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(ev_fall || ev_start || ev_stop)); // R11

endmodule

// File: tb/tb_i2c_mailbox_port.sv
module tb_i2c_mailbox_port;

    localparam int          CLK_PERIOD = 10;
    localparam logic [6:0]  SLV        = 7'h2A;
    localparam logic [6:0]  MBX        = 7'h7F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       proc_wr = 1'b0;
    logic [7:0] proc_data = 8'h00;
    logic       reg_wr;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       req;

    logic [7:0] bank [128];
    logic [7:0] expv [128];
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  mon_on = 1'b0;
    bit  req_low = 1'b0;
    int  oe_bad = 0;
    logic oe_last = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    i2c_mailbox_port #(.SLAVE_ADDR(SLV), .MBOX_ADDR(MBX)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .proc_wr   (proc_wr),
        .proc_data (proc_data),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .req       (req)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) bank[i] <= 8'h00;
        end else if (reg_wr) begin
            bank[reg_addr] <= reg_wdata;
        end
    end

    always @(negedge clk) begin
        if (mon_on && !req) req_low = 1'b1;
        if (rst_n && sda_oe != oe_last && scl_m) oe_bad++;
        oe_last = sda_oe;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fill(input logic [7:0] v);
        proc_data = v;
        proc_wr   = 1'b1;
        tick(1);
        proc_wr   = 1'b0;
    endtask

    task automatic i2c_start();
        if (!scl_m) begin
            tick(5); sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(5);
        end
        sda_m = 1'b0; tick(10); scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        tick(5); sda_m = 1'b0; tick(5); scl_m = 1'b1; tick(10); sda_m = 1'b1; tick(10);
    endtask

    task automatic send_bit(input logic b);
        tick(5); sda_m = b; tick(5); scl_m = 1'b1; tick(10); scl_m = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        tick(5); sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(5);
        ack = !sda_line;
        tick(5); scl_m = 1'b0;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic last, input int fill_at, input logic [7:0] fv);
        for (int i = 0; i < 8; i++) begin
            tick(3); sda_m = 1'b1;
            if (fill_at == i) begin fill(fv); tick(6); end
            else tick(7);
            scl_m = 1'b1; tick(5);
            d[7-i] = sda_line;
            tick(5); scl_m = 1'b0;
        end
        send_bit(last);
    endtask

    task automatic open_read(input logic [6:0] a, input logic inc, input string tag);
        logic ack;
        i2c_start();
        wbyte({SLV, 1'b0}, ack); check(ack, {tag, " addr W ack"}, ack, 1);
        wbyte({inc, a}, ack);    check(ack, "R3 pointer ack", ack, 1);
        i2c_start();
        wbyte({SLV, 1'b1}, ack); check(ack, {tag, " addr R ack"}, ack, 1);
    endtask

    task automatic host_write(input logic [6:0] a, input logic inc, input int n);
        logic ack;
        i2c_start();
        wbyte({SLV, 1'b0}, ack); check(ack, "R2 addr ack", ack, 1);
        wbyte({inc, a}, ack);    check(ack, "R3 pointer ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            wbyte(wbuf[i], ack);
            check(ack, inc ? "R4 data ack" : "R5 data ack", ack, 1);
            expv[inc ? int'(a) + i : int'(a)] = wbuf[i];
        end
        i2c_stop();
    endtask

    task automatic host_read_check(input logic [6:0] a, input logic inc, input int n);
        logic [7:0] d;
        open_read(a, inc, "R6");
        for (int i = 0; i < n; i++) begin
            rbyte(d, (i == n-1), -1, 8'h00);
            rbuf[i] = d;
        end
        i2c_stop();
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            e = expv[inc ? int'(a) + i : int'(a)];
            check(rbuf[i] === e, inc ? "R6/R4 read data" : "R6/R5 read data", rbuf[i], e);
        end
    endtask

    initial begin
        logic       ack;
        logic [7:0] d;
        int         seed_v;
        seed_v = int'($urandom(32'h5EED_0042));
        for (int i = 0; i < 128; i++) expv[i] = 8'h00;

        tick(5); rst_n = 1'b1; tick(5);
        check(req == 1'b0 && sda_oe == 1'b0 && reg_wr == 1'b0, "R1 reset state",
              {req, sda_oe, reg_wr}, 0);

        // R2: mismatched address is not ACKed and nothing is written
        i2c_start();
        wbyte({SLV ^ 7'h01, 1'b0}, ack); check(!ack, "R2 mismatch nack", ack, 0);
        wbyte({1'b0, 7'h05}, ack);       check(!ack, "R2 ignored pointer", ack, 0);
        wbyte(8'h99, ack);               check(!ack, "R2 ignored data", ack, 0);
        i2c_stop();
        check(bank[5] === 8'h00, "R2 no write after mismatch", bank[5], 0);

        // R4: auto-increment burst
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        host_write(7'h10, 1'b1, 3);
        check(bank[16] === 8'h11 && bank[17] === 8'h22 && bank[18] === 8'h33,
              "R4 consecutive regs", {bank[16], bank[17], bank[18]}, 24'h112233);

        // R5: fixed pointer, last byte kept
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        host_write(7'h20, 1'b0, 3);
        check(bank[32] === 8'hC3 && bank[33] === 8'h00, "R5 last byte kept",
              {bank[32], bank[33]}, 16'hC300);

        // R6: read back with increment and without
        host_read_check(7'h10, 1'b1, 3);
        host_read_check(7'h20, 1'b0, 2);

        // R1: STOP in the middle of a data byte writes nothing
        i2c_start();
        wbyte({SLV, 1'b0}, ack);
        wbyte({1'b0, 7'h30}, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        i2c_stop();
        check(bank[48] === 8'h00 && sda_oe == 1'b0, "R1 stop aborts byte", bank[48], 0);

        // Random write/read traffic
        for (int it = 0; it < 24; it++) begin
            logic [6:0] a;
            logic       inc;
            int         n;
            a   = 7'($urandom_range(0, 112));
            inc = 1'($urandom % 2);
            n   = 1 + int'($urandom % 5);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            host_write(a, inc, n);
            host_read_check(a, inc, n);
        end

        // R7/R8: fill, read once, REQ drops after D1
        fill(8'hA5); tick(2);
        check(req == 1'b1, "R7 req after fill", req, 1);
        open_read(MBX, 1'b0, "R7");
        rbyte(d, 1'b1, -1, 8'h00);
        check(d === 8'hA5, "R7 mailbox data", d, 8'hA5);
        check(req == 1'b0, "R8 req low when empty", req, 0);
        i2c_stop();

        // R9: refill before D1 rising edge
        fill(8'h5C); tick(2);
        open_read(MBX, 1'b0, "R9");
        req_low = 1'b0; mon_on = 1'b1;
        rbyte(d, 1'b0, 6, 8'h3D);
        mon_on = 1'b0;
        check(d === 8'h5C, "R9 first byte", d, 8'h5C);
        check(req_low == 1'b0, "R9 req without gap", req_low, 0);
        rbyte(d, 1'b1, -1, 8'h00);
        check(d === 8'h3D, "R9 refilled byte", d, 8'h3D);
        check(req == 1'b0, "R8 req low after second byte", req, 0);
        i2c_stop();

        // R10: refill after D1 rising edge
        fill(8'h6E); tick(2);
        open_read(MBX, 1'b0, "R10");
        req_low = 1'b0; mon_on = 1'b1;
        rbyte(d, 1'b1, 7, 8'h4F);
        mon_on = 1'b0;
        check(d === 8'h6E, "R10 current byte", d, 8'h6E);
        check(req_low == 1'b1, "R10 low pulse seen", req_low, 1);
        check(req == 1'b1, "R10 req reasserted", req, 1);
        i2c_stop();
        open_read(MBX, 1'b0, "R10");
        rbyte(d, 1'b1, -1, 8'h00);
        check(d === 8'h4F, "R10 byte read later", d, 8'h4F);
        i2c_stop();

        check(oe_bad == 0, "R11 sda_oe moved with SCL high", oe_bad, 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule